// File: doc/BRIEF.md
# Hard-Decision Viterbi Decoder

This block recovers the information bits from a stream of convolutionally coded, hard-decision symbols. Each accepted input beat carries one symbol group of `RATE` bits, one bit per generator polynomial. The decoder scores every trellis branch by Hamming distance and keeps, for each state, the cheapest surviving path through add-compare-select. It pulls path metrics back down before they run out of range. It then walks the stored survivor decisions back from the best current state to release one decoded bit for every accepted group. The constraint length, both generator sets and the traceback depth are parameters.

A per-symbol select bit chooses one of two generator sets, so a stream may alternate codes symbol by symbol. A block marker and the select bit enter with each symbol and leave on the output beat that carries that symbol's decoded bit. A flag marks the output beat produced by the step in which the metrics were renormalized. Both stream edges use valid/ready handshaking. A clock enable freezes the block, and a synchronous active-low reset reinitializes it whatever the enable is doing.

Top module: `hd_viterbi`

## Requirements
- R1: After reset, `outValid` is 0 and the trellis starts in the all-zero encoder state: state 0 has metric 0 and all other states hold the largest metric. A correctly coded stream started from an all-zero encoder therefore decodes from its first symbol.
- R2: `inReady` is high only when `ce` is high and the output slot is empty or being drained by `outReady`. A symbol is taken on a rising edge where `inValid` and `inReady` are both high.
- R3: The decoded bit of symbol m is released by the acceptance of symbol m+TB-1. The first `outValid` follows the TB-th accepted symbol.
- R4: With `inSel` at 0 and no channel errors, `outData` reproduces the encoder input bits in order. `inData[j]` carries the parity of generator j, whose taps are `GEN_A[j*K +: K]`. The tap MSB multiplies the newest bit, and the encoder starts at zero.
- R5: Each symbol is scored with `GEN_A` when its `inSel` is 0 and with `GEN_B` when it is 1. A stream that mixes both sets decodes without error.
- R6: A single flipped received bit in every 30 symbols is corrected (default code, TB = 15).
- R7: `outSel` and `outBlock` equal the `inSel` and `inBlock` of the symbol whose decoded bit is on `outData`.
- R8: When every new path metric has its MSB set, that MSB is cleared in all of them. `outNorm` is high on the output beat of that step and only while `outValid` is high. `outNorm` stays low for an error-free stream from reset. Decoding stays correct after a long run of renormalizations.
- R9: While `outValid` is high and the beat is not taken (`outReady` and `ce` not both high), all output fields hold their values.
- R10: With `ce` low, nothing is accepted, `inReady` is low and `outValid` does not change.
- R11: Reset low at a rising edge clears `outValid` even when `ce` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable |
| inValid | input | 1 | Input symbol valid |
| inReady | output | 1 | Decoder can take a symbol |
| inData | input | RATE | Hard received bits, bit j from generator j |
| inSel | input | 1 | Generator set select (0: A, 1: B) |
| inBlock | input | 1 | Block marker travelling with the symbol |
| outValid | output | 1 | Decoded beat valid |
| outReady | input | 1 | Downstream takes the beat |
| outData | output | 1 | Decoded bit |
| outSel | output | 1 | Delayed select of the decoded symbol |
| outBlock | output | 1 | Delayed block marker of the decoded symbol |
| outNorm | output | 1 | Metrics were renormalized in the step that made this beat |

## Verification
In a single edge the decoder can take a new symbol and also have its pending output beat drained. That same edge both refills the single output slot and advances the trellis. Random `outReady`, `ce` and `inValid` gaps make this happen often while a symbol is always pending. The bench judges it by comparing every drained beat, in order, against the encoder bits, select and marker it queued, and by checking that a held beat stays unchanged until it is taken. A noisy stretch long enough to force repeated renormalization, followed by a clean tail, shows that a metric shift on an emitting step neither drops nor misorders decoded bits.

// File: rtl/hd_viterbi_pkg.sv
`timescale 1ns/1ps
package hd_viterbi_pkg;
  // strobes from the control side to the datapath
  typedef struct packed {
    logic step;   // a symbol is accepted this edge
    logic emit;   // that acceptance also loads an output beat
  } vitStrobe_t;
endpackage

// File: rtl/hd_viterbi_ctrl.sv
`timescale 1ns/1ps
module hd_viterbi_ctrl
  import hd_viterbi_pkg::*;
#(
  parameter int TB = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ce,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output vitStrobe_t strb
);
  localparam int CW = $clog2(TB);
  localparam logic [CW-1:0] FILL_LAST = CW'(TB - 1);

  logic [CW-1:0] fillCnt;
  logic          windowFull;

  assign windowFull = (fillCnt == FILL_LAST);

  always_comb begin
    inReady   = ce && (!outValid || outReady);
    strb.step = inValid && inReady;
    strb.emit = strb.step && windowFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      outValid <= 1'b0;
    end else if (ce) begin
      if (strb.step && !windowFull) fillCnt <= fillCnt + 1'b1;
      if (strb.emit)                outValid <= 1'b1;
      else if (outReady)            outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/hd_viterbi_dp.sv
`timescale 1ns/1ps
module hd_viterbi_dp
  import hd_viterbi_pkg::*;
#(
  parameter int K    = 3,
  parameter int RATE = 2,
  parameter int TB   = 15,
  parameter logic [RATE*K-1:0] GEN_A = 6'o75,
  parameter logic [RATE*K-1:0] GEN_B = 6'o57
) (
  input  logic            clk,
  input  logic            rstN,
  input  vitStrobe_t      strb,
  input  logic [RATE-1:0] inData,
  input  logic            inSel,
  input  logic            inBlock,
  output logic            outData,
  output logic            outSel,
  output logic            outBlock,
  output logic            normReg
);
  localparam int SW = K - 1;                         // state bits
  localparam int NS = 1 << SW;                       // trellis states
  localparam int MW = $clog2(TB * RATE) + 2;         // metric width
  localparam int BW = $clog2(RATE + 1);              // branch cost width
  localparam int HD = TB - 2;                        // stored decision vectors

  typedef logic [MW-1:0] metric_t;

  metric_t         pm     [NS];
  metric_t         rawPm  [NS];
  metric_t         nextPm [NS];
  logic [NS-1:0]   dec;
  logic [NS-1:0]   hist   [HD];
  logic [1:0]      tagHist[TB-1];
  logic            allHigh;
  logic [SW-1:0]   bestSt;
  logic [SW-1:0]   tbSt;
  logic [RATE*K-1:0] genSet;

  function automatic logic [RATE-1:0] branchBits(input logic [RATE*K-1:0] g,
                                                 input logic [K-1:0] r);
    logic [RATE-1:0] b;
    for (int j = 0; j < RATE; j++) b[j] = ^(g[j*K +: K] & r);
    return b;
  endfunction

  function automatic logic [BW-1:0] hamming(input logic [RATE-1:0] x);
    logic [BW-1:0] c;
    c = '0;
    for (int j = 0; j < RATE; j++) c = c + BW'(x[j]);
    return c;
  endfunction

  function automatic metric_t satAdd(input metric_t a, input logic [BW-1:0] b);
    logic [MW:0] s;
    s = {1'b0, a} + {{(MW + 1 - BW){1'b0}}, b};
    return s[MW] ? {MW{1'b1}} : s[MW-1:0];
  endfunction

  assign genSet = inSel ? GEN_B : GEN_A;

  // add-compare-select and normalization
  always_comb begin
    logic [SW-1:0] nsv;
    logic [SW-1:0] pred;
    logic [K-1:0]  regBits;
    metric_t       c0;
    metric_t       c1;
    allHigh = 1'b1;
    for (int ns = 0; ns < NS; ns++) begin
      nsv     = SW'(ns);
      pred    = {nsv[SW-2:0], 1'b0};
      regBits = {nsv[SW-1], pred};
      c0      = satAdd(pm[pred], hamming(branchBits(genSet, regBits) ^ inData));
      pred    = {nsv[SW-2:0], 1'b1};
      regBits = {nsv[SW-1], pred};
      c1      = satAdd(pm[pred], hamming(branchBits(genSet, regBits) ^ inData));
      dec[ns]   = (c1 < c0);
      rawPm[ns] = (c1 < c0) ? c1 : c0;
      allHigh   = allHigh & rawPm[ns][MW-1];
    end
    for (int ns = 0; ns < NS; ns++)
      nextPm[ns] = allHigh ? {1'b0, rawPm[ns][MW-2:0]} : rawPm[ns];
  end

  // best state search and traceback
  always_comb begin
    metric_t bestVal;
    bestSt  = '0;
    bestVal = nextPm[0];
    for (int ns = 1; ns < NS; ns++) begin
      if (nextPm[ns] < bestVal) begin
        bestVal = nextPm[ns];
        bestSt  = SW'(ns);
      end
    end
    tbSt = {bestSt[SW-2:0], dec[bestSt]};
    for (int i = 0; i < HD; i++) tbSt = {tbSt[SW-2:0], hist[i][tbSt]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int ns = 0; ns < NS; ns++) pm[ns] <= (ns == 0) ? metric_t'(0) : {MW{1'b1}};
      for (int i = 0; i < HD; i++)     hist[i] <= '0;
      for (int i = 0; i < TB - 1; i++) tagHist[i] <= '0;
      outData  <= 1'b0;
      outSel   <= 1'b0;
      outBlock <= 1'b0;
      normReg  <= 1'b0;
    end else if (strb.step) begin
      for (int ns = 0; ns < NS; ns++) pm[ns] <= nextPm[ns];
      hist[0] <= dec;
      for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
      tagHist[0] <= {inSel, inBlock};
      for (int i = 1; i < TB - 1; i++) tagHist[i] <= tagHist[i-1];
      if (strb.emit) begin
        outData            <= tbSt[SW-1];
        {outSel, outBlock} <= tagHist[TB-2];
        normReg            <= allHigh;
      end
    end
  end
endmodule

// File: rtl/hd_viterbi.sv
`timescale 1ns/1ps
module hd_viterbi
  import hd_viterbi_pkg::*;
#(
  parameter int K    = 3,
  parameter int RATE = 2,
  parameter int TB   = 5 * K,
  parameter logic [RATE*K-1:0] GEN_A = 6'o75,
  parameter logic [RATE*K-1:0] GEN_B = 6'o57
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ce,
  input  logic            inValid,
  output logic            inReady,
  input  logic [RATE-1:0] inData,
  input  logic            inSel,
  input  logic            inBlock,
  output logic            outValid,
  input  logic            outReady,
  output logic            outData,
  output logic            outSel,
  output logic            outBlock,
  output logic            outNorm
);
  vitStrobe_t strb;
  logic       normReg;

  hd_viterbi_ctrl #(.TB(TB)) u_ctrl (
    .clk(clk), .rstN(rstN), .ce(ce), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strb(strb)
  );

  hd_viterbi_dp #(.K(K), .RATE(RATE), .TB(TB), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData), .inSel(inSel),
    .inBlock(inBlock), .outData(outData), .outSel(outSel), .outBlock(outBlock),
    .normReg(normReg)
  );

  assign outNorm = normReg & outValid;
endmodule

// File: rtl/hd_viterbi_chk.sv
`timescale 1ns/1ps
module hd_viterbi_chk (
  input logic clk,
  input logic rstN,
  input logic ce,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input logic outData,
  input logic outSel,
  input logic outBlock,
  input logic outNorm
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rstN |=> !outValid);

  assert_reset_over_ce_R11: assert property (@(posedge clk) (!rstN && !ce) |=> !outValid);

  assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  assert_emit_on_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));

  assert_norm_on_beat_R8: assert property (@(posedge clk) disable iff (!rstN)
    outNorm |-> outValid);

  assert_hold_beat_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(outReady && ce)) |=>
      (outValid && $stable(outData) && $stable(outSel) && $stable(outBlock) && $stable(outNorm)));

  assert_ce_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ce |-> !inReady);

  assert_ce_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ce |=> $stable(outValid));
endmodule

bind hd_viterbi hd_viterbi_chk u_chk (
  .clk(clk), .rstN(rstN), .ce(ce), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outSel(outSel),
  .outBlock(outBlock), .outNorm(outNorm)
);

// File: tb/hd_viterbi_bench.sv
`timescale 1ns/1ps
module hd_viterbi_bench;
  localparam int K    = 3;
  localparam int RATE = 2;
  localparam int TB   = 15;
  localparam int SW   = K - 1;
  localparam logic [RATE*K-1:0] GA = 6'o75;
  localparam logic [RATE*K-1:0] GB = 6'o57;

  logic clk = 1'b0;
  logic rstN, ce, inValid, inReady, inSel, inBlock;
  logic outValid, outReady, outData, outSel, outBlock, outNorm;
  logic [RATE-1:0] inData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bit sentBit [4096];
  bit sentSel [4096];
  bit sentBlk [4096];

  always #2.5 clk = ~clk;

  hd_viterbi #(.K(K), .RATE(RATE), .TB(TB), .GEN_A(GA), .GEN_B(GB)) u_hd_viterbi (
    .clk(clk), .rstN(rstN), .ce(ce), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inSel(inSel), .inBlock(inBlock), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outSel(outSel), .outBlock(outBlock),
    .outNorm(outNorm)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=%0d cycles expected=fewer", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [RATE-1:0] encode(input logic [RATE*K-1:0] g, input logic [K-1:0] r);
    logic [RATE-1:0] b;
    for (int j = 0; j < RATE; j++) b[j] = ^(g[j*K +: K] & r);
    return b;
  endfunction

  task automatic doReset();
    rstN = 1'b0; ce = 1'b1; inValid = 1'b0; outReady = 1'b0;
    inData = '0; inSel = 1'b0; inBlock = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    check(inReady == 1'b1, "R2 inReady after reset", inReady, 1);
  endtask

  // drives one stream and checks every drained beat against the queued symbols
  task automatic runPhase(input int nSym, input bit dualSel, input int errEvery,
                          input int noisyUntil, input bit normExpected,
                          input int checkFrom, input string dataReq);
    int total, nAcc, nRecv, normSeen;
    bit haveSym, firstSeen, heldValid;
    logic heldData, heldSel, heldBlk, heldNorm;
    logic [SW-1:0] encSt, pendNext;
    logic [RATE-1:0] pd;
    logic pendBit, pendSel, pendBlk;
    logic [K-1:0] regv;
    total = nSym + TB - 1;
    nAcc = 0; nRecv = 0; normSeen = 0;
    haveSym = 0; firstSeen = 0; heldValid = 0;
    heldData = 0; heldSel = 0; heldBlk = 0; heldNorm = 0;
    encSt = '0; pendNext = '0; pd = '0; pendBit = 0; pendSel = 0; pendBlk = 0;
    while (nAcc < total || nRecv < nSym) begin
      @(negedge clk);
      if (!haveSym && nAcc < total) begin
        pendBit = (nAcc < nSym) ? 1'($urandom % 2) : 1'b0;
        pendSel = dualSel ? 1'($urandom % 2) : 1'b0;
        pendBlk = (nAcc % 16 == 3);
        regv = {pendBit, encSt};
        pd = encode(pendSel ? GB : GA, regv);
        if (errEvery > 0 && nAcc < nSym && (nAcc % errEvery) == errEvery / 2)
          pd[nAcc % RATE] = ~pd[nAcc % RATE];
        if (nAcc < noisyUntil) pd = RATE'($urandom);
        pendNext = {pendBit, encSt[SW-1:1]};
        haveSym = 1;
      end
      inValid  = haveSym && ($urandom % 4 != 0);
      inData   = pd; inSel = pendSel; inBlock = pendBlk;
      outReady = ($urandom % 4 != 0);
      ce       = ($urandom % 8 != 0);
      #1;
      if (heldValid) begin
        check(outValid && outData == heldData && outSel == heldSel &&
              outBlock == heldBlk && outNorm == heldNorm, "R9 held beat", outData, heldData);
      end
      heldValid = outValid && !(outReady && ce);
      heldData = outData; heldSel = outSel; heldBlk = outBlock; heldNorm = outNorm;
      if (!ce) check(!inReady, "R10 inReady with ce low", inReady, 0);
      if (outValid && !outReady) check(!inReady, "R2 inReady under backpressure", inReady, 0);
      if (outValid && !firstSeen) begin
        firstSeen = 1;
        check(nAcc == TB, "R3 first output latency", nAcc, TB);
      end
      if (outValid && outReady && ce) begin
        if (nRecv >= checkFrom)
          check(outData == sentBit[nRecv], dataReq, outData, sentBit[nRecv]);
        check(outSel == sentSel[nRecv] && outBlock == sentBlk[nRecv], "R7 delayed tags",
              {outSel, outBlock}, {sentSel[nRecv], sentBlk[nRecv]});
        if (normExpected) begin
          if (outNorm) normSeen++;
        end else begin
          check(outNorm == 1'b0, "R8 no norm on clean stream", outNorm, 0);
        end
        nRecv++;
      end
      if (inValid && inReady) begin
        sentBit[nAcc] = pendBit; sentSel[nAcc] = pendSel; sentBlk[nAcc] = pendBlk;
        encSt = pendNext;
        nAcc++;
        haveSym = 0;
      end
    end
    @(negedge clk);
    inValid = 1'b0; ce = 1'b1;
    if (normExpected) check(normSeen > 0, "R8 normalization seen", normSeen, 1);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd1234));
    doReset();
    runPhase(200, 1'b0, 0, 0, 1'b0, 0, "R4 clean decode set A");
    doReset();
    runPhase(200, 1'b1, 0, 0, 1'b0, 0, "R5 dual generator decode");
    doReset();
    runPhase(300, 1'b0, 30, 0, 1'b0, 0, "R6 single error correction");
    doReset();
    runPhase(1500, 1'b0, 0, 1200, 1'b1, 1230, "R8 decode after normalization");

    // ce freeze and reset with ce low
    doReset();
    outReady = 1'b0; cnt = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      inValid = 1'b1; inData = '0; inSel = 1'b0; inBlock = 1'b0;
      #1;
      if (outValid) break;
      if (inReady) cnt++;
    end
    check(outValid == 1'b1, "R3 beat pending before freeze", outValid, 1);
    @(negedge clk);
    ce = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(outValid == 1'b1 && inReady == 1'b0, "R10 frozen with ce low", {outValid, inReady}, 2);
    end
    rstN = 1'b0;
    @(negedge clk);
    #1;
    check(outValid == 1'b0, "R11 reset with ce low", outValid, 0);
    @(negedge clk);
    rstN = 1'b1; ce = 1'b1; inValid = 1'b0;
    runPhase(40, 1'b0, 0, 0, 1'b0, 0, "R1 restart after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule